// File: doc/BRIEF.md
# Write-Back Set-Associative Data Cache

This block sits between a load/store unit and a backing memory. The core presents one 32-bit load or store at a time, with a byte strobe for stores, and holds it until the cache raises `req_ready`. Tag, valid and dirty state are looked up combinationally in the same cycle as the request. A hit is accepted in that cycle, and load data follows one cycle later on `rsp_rdata`. A miss holds `req_ready` low while the line is brought in as 128-bit beats, and a dirty victim is copied out first.

The geometry is set by parameters: number of sets, number of ways, line size and bus width. The defaults are 16 sets, 4 ways, 64-byte lines and a 128-bit bus, which gives 4 KB. Each way keeps its line data in a bank of its own. Replacement picks the lowest-numbered invalid way if the set has one, and otherwise the least recently used way, tracked with per-set age counters. Stores allocate on a miss: the line is filled and then the strobed bytes are merged into it and the line is marked dirty.

The memory side has two channels that can be used in the same cycle. A read channel takes beat addresses and returns data with a valid strobe. A write channel carries write-back beats.

Top module: `wb_dcache`

## Requirements
- R1: A load that hits is accepted (`req_ready` high) in the cycle it is presented. `rsp_valid` rises in the next cycle with the addressed 32-bit word on `rsp_rdata`.
- R2: A store that hits is accepted in the cycle it is presented. It writes only the bytes whose `req_be` bit is set (bit n covers `req_wdata[8n+7:8n]`), and later loads of that word return the merged value. Accesses are word aligned (`req_addr[1:0]` is 0).
- R3: With a backing memory that answers each read beat in the following cycle, a miss on a clean or invalid victim is accepted 7 cycles after it is first presented. It issues exactly four reads to the line's beat addresses, base + 0, 16, 32 and 48, in that order.
- R4: A miss whose victim is valid and dirty is accepted 10 cycles after it is first presented. It first writes the victim's four beats, at ascending addresses, holding the victim's current data. No fill read is issued before the cycle of the last write beat. A miss on a clean victim writes nothing to memory.
- R5: A store miss fills the line and then merges the strobed bytes. Bytes outside the strobe keep their memory values. The line becomes dirty, so its later eviction writes it back.
- R6: The victim is the lowest-numbered invalid way of the set when one exists, otherwise the least recently accessed way. Index is address bits [9:6] and tag bits [31:10] at default geometry.
- R7: Hits cause no memory traffic, and `req_ready` stays low while a miss is in service.
- R8: After reset no line is valid, and `rsp_valid`, `mem_rd_valid` and `mem_wr_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present, held until accepted |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address, word aligned |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte strobe |
| req_ready | output | 1 | Request accepted this cycle |
| rsp_valid | output | 1 | Load data valid |
| rsp_rdata | output | 32 | Load data |
| mem_rd_valid | output | 1 | Fill read beat request |
| mem_rd_addr | output | 32 | Fill beat byte address |
| mem_rvalid | input | 1 | Fill beat data valid |
| mem_rdata | input | 128 | Fill beat data |
| mem_wr_valid | output | 1 | Write-back beat valid |
| mem_wr_addr | output | 32 | Write-back beat byte address |
| mem_wr_data | output | 128 | Write-back beat data |

## Verification
The hardest case to reach from the ports is an eviction of a dirty line that has been chosen as least recently used. Reaching it takes a set whose four ways are all filled, a store to one of them, and an exact recency order. The bench reaches it with addresses 1 KB apart, which land in the same set, and with chosen hits that make the dirty line the oldest. It then checks the 10-cycle acceptance, the write-back addresses and the merged bytes that arrive in backing memory, and reloads the evicted line to confirm the data comes back. Store-miss allocation gets the same treatment in a second set.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

   typedef enum logic [1:0] {
      ST_LOOKUP = 2'd0,
      ST_EVICT  = 2'd1,
      ST_REFILL = 2'd2
   } dc_state_e;

   function automatic int unsigned dc_log2(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((1 << r) < v) r++;
      return r;
   endfunction

endpackage

// File: rtl/dcache_bank.sv
module dcache_bank #(
   parameter int DEPTH  = 64,
   parameter int DW     = 128,
   localparam int AW    = $clog2(DEPTH),
   localparam int NBYTE = DW / 8
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [NBYTE-1:0] wstrb,
   input  logic [DW-1:0]    wdata,
   input  logic [AW-1:0]    raddr,
   output logic [DW-1:0]    rdata
);

   logic [DW-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         for (int b = 0; b < NBYTE; b++) begin
            if (wstrb[b]) mem_q[waddr][b*8 +: 8] <= wdata[b*8 +: 8];
         end
      end
   end

   assign rdata = mem_q[raddr];

endmodule

// File: rtl/dcache_tags.sv
module dcache_tags #(
   parameter int SETS  = 16,
   parameter int WAYS  = 4,
   parameter int TAG_W = 22,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_en,
   input  logic [IDX_W-1:0] lk_idx,
   input  logic [TAG_W-1:0] lk_tag,
   input  logic [WAY_W-1:0] sel_way,
   output logic [WAYS-1:0]  hit_vec,
   output logic [WAYS-1:0]  valid_vec,
   output logic [WAYS-1:0]  dirty_vec,
   output logic [TAG_W-1:0] sel_tag,
   input  logic             fill_en,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic [WAY_W-1:0] fill_way,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic             mark_en,
   input  logic [IDX_W-1:0] mark_idx,
   input  logic [WAY_W-1:0] mark_way
);

   logic [TAG_W-1:0] tag_q   [SETS][WAYS];
   logic [WAYS-1:0]  valid_q [SETS];
   logic [WAYS-1:0]  dirty_q [SETS];

   always_ff @(posedge clk) begin
      if (fill_en) tag_q[fill_idx][fill_way] <= fill_tag;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            valid_q[s] <= '0;
            dirty_q[s] <= '0;
         end
      end else begin
         if (fill_en) begin
            valid_q[fill_idx][fill_way] <= 1'b1;
            dirty_q[fill_idx][fill_way] <= 1'b0;
         end
         if (mark_en) dirty_q[mark_idx][mark_way] <= 1'b1;
      end
   end

   assign valid_vec = valid_q[lk_idx];
   assign dirty_vec = dirty_q[lk_idx];
   assign sel_tag   = tag_q[lk_idx][sel_way];

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = lk_en && valid_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
   end

   // R6
   multi_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

endmodule

// File: rtl/dcache_lru.sv
module dcache_lru #(
   parameter int SETS = 16,
   parameter int WAYS = 4,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic [WAYS-1:0]  valid_vec,
   input  logic             touch_en,
   input  logic [IDX_W-1:0] touch_idx,
   input  logic [WAY_W-1:0] touch_way,
   output logic [WAY_W-1:0] victim
);

   if (WAYS == 1) begin : g_direct
      logic unused_in;
      assign unused_in = ^{idx, valid_vec, touch_en, touch_idx, touch_way, clk, rst_n};
      assign victim    = '0;
   end else begin : g_age
      localparam int AGE_W = WAY_W;
      logic [AGE_W-1:0] age_q [SETS][WAYS];
      logic [AGE_W-1:0] t_age;

      assign t_age = age_q[touch_idx][touch_way];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
               for (int w = 0; w < WAYS; w++)
                  age_q[s][w] <= AGE_W'(w);
         end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
               if (WAY_W'(w) == touch_way)
                  age_q[touch_idx][w] <= '0;
               else if (age_q[touch_idx][w] < t_age)
                  age_q[touch_idx][w] <= age_q[touch_idx][w] + 1'b1;
            end
         end
      end

      always_comb begin
         logic found;
         found  = 1'b0;
         victim = '0;
         for (int w = 0; w < WAYS; w++) begin
            if (!valid_vec[w] && !found) begin
               victim = WAY_W'(w);
               found  = 1'b1;
            end
         end
         if (!found) begin
            for (int w = 0; w < WAYS; w++)
               if (age_q[idx][w] == AGE_W'(WAYS - 1)) victim = WAY_W'(w);
         end
      end

      // R6
      free_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(&valid_vec) |-> !valid_vec[victim]);
   end

endmodule

// File: rtl/wb_dcache.sv
module wb_dcache #(
   parameter int ADDR_W     = 32,
   parameter int WORD_W     = 32,
   parameter int BUS_W      = 128,
   parameter int LINE_BYTES = 64,
   parameter int SETS       = 16,
   parameter int WAYS       = 4,
   localparam int WBYTES    = WORD_W / 8,
   localparam int BBYTES    = BUS_W / 8,
   localparam int BEATS     = LINE_BYTES / BBYTES,
   localparam int WPB       = BBYTES / WBYTES,
   localparam int BOFF_W    = $clog2(BBYTES),
   localparam int BEAT_W    = $clog2(BEATS),
   localparam int WSEL_W    = $clog2(WPB),
   localparam int WOFF_W    = $clog2(WBYTES),
   localparam int OFF_W     = BOFF_W + BEAT_W,
   localparam int IDX_W     = $clog2(SETS),
   localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
   localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1,
   localparam int CNT_W     = BEAT_W + 1,
   localparam int BK_AW     = IDX_W + BEAT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [WORD_W-1:0] req_wdata,
   input  logic [WBYTES-1:0] req_be,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [WORD_W-1:0] rsp_rdata,
   output logic              mem_rd_valid,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rvalid,
   input  logic [BUS_W-1:0]  mem_rdata,
   output logic              mem_wr_valid,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [BUS_W-1:0]  mem_wr_data
);
   import dcache_pkg::*;

   initial begin
      if (BEATS < 2 || (BEATS & (BEATS - 1)) != 0)
         $fatal(1, "line must hold a power-of-two count of at least two bus beats");
      if (WPB < 2) $fatal(1, "bus must carry at least two words");
      if ((SETS & (SETS - 1)) != 0 || SETS < 2) $fatal(1, "set count must be a power of two");
      if (WAYS < 1) $fatal(1, "at least one way is needed");
      if (TAG_W < 1) $fatal(1, "address too narrow for geometry");
   end

   // address fields
   logic [TAG_W-1:0]  req_tag;
   logic [IDX_W-1:0]  req_idx;
   logic [BEAT_W-1:0] req_beat;
   logic [WSEL_W-1:0] req_wsel;
   assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
   assign req_idx  = req_addr[OFF_W +: IDX_W];
   assign req_beat = req_addr[BOFF_W +: BEAT_W];
   assign req_wsel = req_addr[WOFF_W +: WSEL_W];

   // control state
   dc_state_e         state_q;
   logic [IDX_W-1:0]  miss_idx_q;
   logic [TAG_W-1:0]  miss_tag_q;
   logic [TAG_W-1:0]  vic_tag_q;
   logic [WAY_W-1:0]  vic_way_q;
   logic [CNT_W-1:0]  wb_cnt_q, rd_cnt_q, rx_cnt_q;

   // lookup
   logic              lookup;
   logic [WAYS-1:0]   hit_vec, valid_vec, dirty_vec;
   logic [TAG_W-1:0]  vic_tag;
   logic [WAY_W-1:0]  victim, hit_way;
   logic              hit;

   assign lookup = req_valid && (state_q == ST_LOOKUP);
   assign hit    = |hit_vec;

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++)
         if (hit_vec[w]) hit_way = WAY_W'(w);
   end

   assign req_ready = lookup && hit;

   logic st_hit, ld_hit, miss_start, wb_last, rd_go, fill_beat, fill_done;
   assign st_hit     = req_ready && req_we;
   assign ld_hit     = req_ready && !req_we;
   assign miss_start = lookup && !hit;
   assign wb_last    = (state_q == ST_EVICT) && (wb_cnt_q == CNT_W'(BEATS - 1));
   assign rd_go      = ((state_q == ST_REFILL) && (rd_cnt_q != CNT_W'(BEATS))) || wb_last;
   assign fill_beat  = (state_q == ST_REFILL) && mem_rvalid;
   assign fill_done  = fill_beat && (rx_cnt_q == CNT_W'(BEATS - 1));

   dcache_tags #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_en    (lookup),
      .lk_idx   (req_idx),
      .lk_tag   (req_tag),
      .sel_way  (victim),
      .hit_vec  (hit_vec),
      .valid_vec(valid_vec),
      .dirty_vec(dirty_vec),
      .sel_tag  (vic_tag),
      .fill_en  (fill_done),
      .fill_idx (miss_idx_q),
      .fill_way (vic_way_q),
      .fill_tag (miss_tag_q),
      .mark_en  (st_hit),
      .mark_idx (req_idx),
      .mark_way (hit_way)
   );

   dcache_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx      (req_idx),
      .valid_vec(valid_vec),
      .touch_en (req_ready),
      .touch_idx(req_idx),
      .touch_way(hit_way),
      .victim   (victim)
   );

   // data banks, one per way
   logic [BUS_W-1:0]  bank_rd [WAYS];
   logic [BK_AW-1:0]  bk_raddr, bk_waddr;
   logic [BBYTES-1:0] bk_wstrb, st_strb;
   logic [BUS_W-1:0]  bk_wdata;

   assign st_strb  = BBYTES'(req_be) << (WBYTES * req_wsel);
   assign bk_raddr = (state_q == ST_EVICT) ? {miss_idx_q, wb_cnt_q[BEAT_W-1:0]}
                                           : {req_idx, req_beat};
   assign bk_waddr = fill_beat ? {miss_idx_q, rx_cnt_q[BEAT_W-1:0]} : {req_idx, req_beat};
   assign bk_wstrb = fill_beat ? {BBYTES{1'b1}} : st_strb;
   assign bk_wdata = fill_beat ? mem_rdata : {WPB{req_wdata}};

   for (genvar g = 0; g < WAYS; g++) begin : g_way
      logic bk_we;
      assign bk_we = (st_hit && hit_vec[g]) || (fill_beat && (vic_way_q == WAY_W'(g)));
      dcache_bank #(.DEPTH(SETS * BEATS), .DW(BUS_W)) u_bank (
         .clk  (clk),
         .we   (bk_we),
         .waddr(bk_waddr),
         .wstrb(bk_wstrb),
         .wdata(bk_wdata),
         .raddr(bk_raddr),
         .rdata(bank_rd[g])
      );
   end

   logic [BUS_W-1:0] hit_beat;
   assign hit_beat = bank_rd[hit_way];

   // miss sequencing
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_LOOKUP;
         miss_idx_q <= '0;
         miss_tag_q <= '0;
         vic_tag_q  <= '0;
         vic_way_q  <= '0;
         wb_cnt_q   <= '0;
         rd_cnt_q   <= '0;
         rx_cnt_q   <= '0;
      end else begin
         if (rd_go) rd_cnt_q <= rd_cnt_q + 1'b1;
         unique case (state_q)
            ST_LOOKUP: begin
               if (miss_start) begin
                  miss_idx_q <= req_idx;
                  miss_tag_q <= req_tag;
                  vic_way_q  <= victim;
                  vic_tag_q  <= vic_tag;
                  wb_cnt_q   <= '0;
                  rd_cnt_q   <= '0;
                  rx_cnt_q   <= '0;
                  state_q    <= (valid_vec[victim] && dirty_vec[victim]) ? ST_EVICT : ST_REFILL;
               end
            end
            ST_EVICT: begin
               wb_cnt_q <= wb_cnt_q + 1'b1;
               if (wb_last) state_q <= ST_REFILL;
            end
            ST_REFILL: begin
               if (fill_beat) rx_cnt_q <= rx_cnt_q + 1'b1;
               if (fill_done) state_q <= ST_LOOKUP;
            end
            default: state_q <= ST_LOOKUP;
         endcase
      end
   end

   // memory side
   assign mem_rd_valid = rd_go;
   assign mem_rd_addr  = {miss_tag_q, miss_idx_q, rd_cnt_q[BEAT_W-1:0], {BOFF_W{1'b0}}};
   assign mem_wr_valid = (state_q == ST_EVICT);
   assign mem_wr_addr  = {vic_tag_q, miss_idx_q, wb_cnt_q[BEAT_W-1:0], {BOFF_W{1'b0}}};
   assign mem_wr_data  = bank_rd[vic_way_q];

   // load response
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= ld_hit;
         if (ld_hit) rsp_rdata <= hit_beat[req_wsel*WORD_W +: WORD_W];
      end
   end

   // R1
   hit_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && !req_we) |=> rsp_valid);

   // R2
   align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_addr[WOFF_W-1:0] == '0));

   // R4
   wb_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && mem_wr_valid) |-> (mem_wr_addr[BOFF_W +: BEAT_W] == BEAT_W'(BEATS - 1)));

   // R3
   rvalid_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rvalid |-> (state_q == ST_REFILL));

   // R7
   stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid || mem_wr_valid) |-> !req_ready);

endmodule

// File: tb/sim_wb_dcache.sv
`timescale 1ns/1ps
module sim_wb_dcache;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0, req_we = 1'b0;
   logic [31:0]  req_addr = '0, req_wdata = '0;
   logic [3:0]   req_be = '0;
   logic         req_ready, rsp_valid;
   logic [31:0]  rsp_rdata;
   logic         mem_rd_valid, mem_wr_valid;
   logic [31:0]  mem_rd_addr, mem_wr_addr;
   logic [127:0] mem_wr_data;
   logic         mem_rvalid = 1'b0;
   logic [127:0] mem_rdata = '0;

   always #2 clk = ~clk;

   wb_dcache u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
   );

   int n_tests = 0, n_fail = 0;
   bit done = 0;

   function automatic logic [31:0] pat(input logic [31:0] a);
      return (a * 32'h0001_0003) ^ 32'hA5C3_1E00;
   endfunction

   // backing memory, one-cycle read latency
   logic [127:0] bmem [1024];
   logic [31:0]  rlog[$], wlog[$];

   initial begin
      for (int i = 0; i < 1024; i++)
         for (int k = 0; k < 4; k++)
            bmem[i][k*32 +: 32] = pat(32'(i*16 + k*4));
   end

   always @(posedge clk) begin
      if (mem_wr_valid) begin
         bmem[mem_wr_addr[13:4]] <= mem_wr_data;
         wlog.push_back(mem_wr_addr);
      end
      mem_rvalid <= mem_rd_valid;
      if (mem_rd_valid) begin
         mem_rdata <= bmem[mem_rd_addr[13:4]];
         rlog.push_back(mem_rd_addr);
      end
   end

   // architectural reference
   logic [31:0] refm [logic [31:0]];
   function automatic logic [31:0] ref_rd(input logic [31:0] a);
      return refm.exists(a) ? refm[a] : pat(a);
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   // scoreboard
   logic [31:0] exp_q[$];
   string       exp_rq[$];

   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) chk(0, "R1", "unexpected response", rsp_rdata, 0);
         else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = exp_rq.pop_front();
            chk(rsp_rdata == e, t, "load data", rsp_rdata, e);
         end
      end
   end

   task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                         input logic [3:0] be, input int exp_lat, input string rq);
      int lat;
      @(negedge clk);
      req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
      if (we) begin
         logic [31:0] nw;
         nw = ref_rd(a);
         for (int b = 0; b < 4; b++) if (be[b]) nw[b*8 +: 8] = d[b*8 +: 8];
         refm[a] = nw;
      end else begin
         exp_q.push_back(ref_rd(a));
         exp_rq.push_back(rq);
      end
      lat = 1;
      #1;
      while (!req_ready && lat < 100) begin
         @(negedge clk); #1; lat++;
      end
      chk(lat == exp_lat, rq, "accept latency", lat, exp_lat);
      @(negedge clk);
      req_valid = 1'b0; req_we = 1'b0;
   endtask

   task automatic chk_line_log(input logic [31:0] lg[$], input int from, input logic [31:0] base,
                               input string rq, input string what);
      chk(lg.size() - from == 4, rq, {what, " beat count"}, lg.size() - from, 4);
      if (lg.size() - from == 4)
         for (int k = 0; k < 4; k++)
            chk(lg[from+k] == base + 32'(k*16), rq, {what, " beat address"}, lg[from+k], base + 32'(k*16));
   endtask

   localparam logic [31:0] A = 32'h0100, B = 32'h0500, C = 32'h0900, D = 32'h0D00, E = 32'h1100;
   localparam logic [31:0] G = 32'h2008;

   initial begin
      int r0, w0;
      repeat (3) @(negedge clk);
      // R8: reset state
      chk(rsp_valid == 0, "R8", "rsp_valid in reset", rsp_valid, 0);
      chk(mem_rd_valid == 0 && mem_wr_valid == 0, "R8", "mem request in reset",
          {mem_rd_valid, mem_wr_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 0 && rsp_valid == 0, "R8", "idle outputs after reset",
          {req_ready, rsp_valid}, 0);
      chk(mem_rd_valid == 0 && mem_wr_valid == 0, "R8", "mem idle after reset",
          {mem_rd_valid, mem_wr_valid}, 0);

      // R3/R8: first access misses, clean fill of four beats
      r0 = rlog.size(); w0 = wlog.size();
      access(0, A, 0, 0, 7, "R3");
      chk_line_log(rlog, r0, A, "R3", "fill");
      chk(wlog.size() == w0, "R4", "clean miss writes", wlog.size() - w0, 0);

      // R1/R7: hits, no traffic
      r0 = rlog.size();
      access(0, A + 4, 0, 0, 1, "R1");
      access(0, A + 32'h34, 0, 0, 1, "R1");
      chk(rlog.size() == r0, "R7", "hit reads memory", rlog.size() - r0, 0);

      // R2: strobed store merges
      access(1, A + 8, 32'hDEADBEEF, 4'b0101, 1, "R2");
      access(0, A + 8, 0, 0, 1, "R2");
      access(1, A + 8, 32'h11223344, 4'b1000, 1, "R2");
      access(0, A + 8, 0, 0, 1, "R2");
      access(1, A + 32'h3C, 32'h0BADF00D, 4'b1111, 1, "R2");
      chk(wlog.size() == w0, "R7", "store hit writes memory", wlog.size() - w0, 0);

      // R6: invalid ways are used before evicting
      access(0, B, 0, 0, 7, "R6");
      access(0, C, 0, 0, 7, "R6");
      access(0, D, 0, 0, 7, "R6");
      access(0, A, 0, 0, 1, "R6");
      // recency A,D,C,B -> B is LRU and clean
      w0 = wlog.size();
      access(0, E, 0, 0, 7, "R6");
      chk(wlog.size() == w0, "R4", "clean eviction writes", wlog.size() - w0, 0);
      access(0, C, 0, 0, 1, "R6");
      access(0, D, 0, 0, 1, "R6");
      access(0, E, 0, 0, 1, "R6");
      // recency E,D,C,A -> dirty A is LRU
      w0 = wlog.size(); r0 = rlog.size();
      access(0, B, 0, 0, 10, "R4");
      chk_line_log(wlog, w0, A, "R4", "write-back");
      chk_line_log(rlog, r0, B, "R4", "fill after write-back");
      chk(bmem[(A + 8) >> 4][64 +: 32] == ref_rd(A + 8), "R4", "written-back merged word",
          bmem[(A + 8) >> 4][64 +: 32], ref_rd(A + 8));
      chk(bmem[(A + 32'h3C) >> 4][96 +: 32] == ref_rd(A + 32'h3C), "R4", "written-back word",
          bmem[(A + 32'h3C) >> 4][96 +: 32], ref_rd(A + 32'h3C));
      // recency B,E,D,C -> C clean; A returns from memory
      access(0, A + 8, 0, 0, 7, "R6");
      access(0, C, 0, 0, 7, "R6");

      // R5: write-allocate
      r0 = rlog.size();
      access(1, G, 32'hCAFEF00D, 4'b1111, 7, "R5");
      chk_line_log(rlog, r0, G & ~32'h3F, "R5", "allocate fill");
      access(0, G, 0, 0, 1, "R5");
      access(0, G + 4, 0, 0, 1, "R5");
      access(1, 32'h0044, 32'h77665544, 4'b0110, 7, "R5");
      access(0, 32'h0044, 0, 0, 1, "R5");
      access(0, 32'h2400, 0, 0, 7, "R5");
      access(0, 32'h2800, 0, 0, 7, "R5");
      access(0, 32'h2C00, 0, 0, 7, "R5");
      w0 = wlog.size();
      access(0, 32'h3000, 0, 0, 10, "R5");
      chk_line_log(wlog, w0, G & ~32'h3F, "R5", "allocated line write-back");
      chk(bmem[G >> 4][64 +: 32] == 32'hCAFEF00D, "R5", "allocated store in memory",
          bmem[G >> 4][64 +: 32], 32'hCAFEF00D);

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R1", "responses outstanding", exp_q.size(), 0);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule